// File: doc/BRIEF.md
# Almost-Empty / Almost-Full Offset Register Sequencer

This block holds the two threshold offsets a FIFO's partial flags compare against. The almost-empty offset n goes to the read-side flag logic. The almost-full offset m goes to the write-side flag logic. Each offset is stored as an 8-bit low part and a narrow high part that carries the remaining bits the FIFO depth needs. That makes four storage slots.

No address reaches these slots. One sequencer on the write clock and one on the read clock each step through the slots in a fixed cycle and wrap around. Software loads the slots from the data input and reads them back on the data output, one slot per access. It may stop partway and resume later at the slot that follows.

The write domain owns the slots, so m is used there directly. After a burst of loads ends, the write side sends one toggle event to the read clock through a two-flop synchronizer. The read side then takes a shadow copy of all four slots. That shadow copy supplies n and the readback data. Whether the pin doubles as a load control or as a second write enable is fixed while reset is held. In the second-enable mode the block stays at its defaults and ignores every access.

Sequencer states are `SEL_AE_LO`, `SEL_AE_HI`, `SEL_AF_LO` and `SEL_AF_HI`. Transition *step* moves to the next state in that list. Transition *wrap* goes from `SEL_AF_HI` back to `SEL_AE_LO`. Transition *hold* keeps the state when no access fires. Reset forces `SEL_AE_LO`.

Top module: `ofs_regfile`

## Requirements
- R1: Slot writes follow the fixed order n-low, n-high, m-low, m-high and then wrap to n-low. The state index is 0, 1, 2, 3 in that order.
- R2: A slot write happens on a rising wr_clk edge only when ld_n = 0 and wen1_n = 0. Either input high leaves all slots and the write sequencer unchanged.
- R3: A load burst may stop when ld_n goes high. The next write with ld_n low goes to the slot after the last one written.
- R4: Readback happens on a rising rd_clk edge only when ld_n = 0, ren1_n = 0 and ren2_n = 0. It puts the current slot on rd_data and advances the read sequencer through the same order as R1. If any enable is high, rd_data and the read sequencer hold.
- R5: A low slot stores din[7:0]. A high slot stores din[HI_W-1:0], where HI_W = max(1, clog2(DEPTH) - 8). On readback a slot is zero-extended to DW bits. An offset is {high, low}.
- R6: Reset sets n and m to 7 and both sequencers to n-low. It also clears rd_data to 0 and clears clash_err.
- R7: A read request while a slot update is still crossing into the read clock is not executed. rd_data and the read sequencer hold, and clash_err sets and stays set until reset. The write still takes effect.
- R8: If ld_n is high while reset is held, slot writes and readbacks are ignored until the next reset. n and m stay 7 and rd_data stays 0.
- R9: af_ofs shows a written m slot from the next wr_clk cycle. ae_ofs keeps its old value at the first rd_clk edge after a write and shows the new value no later than the fifth rd_clk edge after the last write of a burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous reset for both domains, active low |
| ld_n | input | 1 | Load control, active low; while reset is held it selects the mode |
| wen1_n | input | 1 | Write enable 1, active low |
| din | input | DW | Write data |
| ren1_n | input | 1 | Read enable 1, active low |
| ren2_n | input | 1 | Read enable 2, active low |
| rd_data | output | DW | Readback output register |
| clash_err | output | 1 | Sticky read/write collision flag |
| ae_ofs | output | 8+HI_W | Almost-empty offset n, read-clock copy |
| af_ofs | output | 8+HI_W | Almost-full offset m, write-clock copy |

## Verification
The assertions check these properties on every cycle:
- Each sequencer wraps correctly and holds when no access fires, and its state stays one-hot.
- Slots and rd_data change only on a qualifying access.
- The read-side shadow changes only while the synchronizer reports an update in flight.
- clash_err is sticky.
- The second-enable mode keeps the defaults.

Only the bench scenarios can show that the data values themselves are right. This covers the slot order across several wraps, resuming after a paused burst, zero extension and masking of the high slots, and the exact rd_clk edge at which a read collides with a crossing update. It also covers the bound on how long ae_ofs takes to follow a write.

// File: rtl/ofs_pkg.sv
package ofs_pkg;

    localparam int LO_W    = 8;
    localparam int OFS_DEF = 7;

    typedef enum logic [1:0] {
        SEL_AE_LO = 2'd0,
        SEL_AE_HI = 2'd1,
        SEL_AF_LO = 2'd2,
        SEL_AF_HI = 2'd3
    } ofs_sel_e;

endpackage

// File: rtl/ofs_seq.sv
module ofs_seq
    import ofs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       step,
    output logic [3:0] sel_oh
);

    ofs_sel_e cur_q;
    ofs_sel_e nxt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= SEL_AE_LO;
        else        cur_q <= nxt;
    end

    // transitions: step / wrap / hold
    always_comb begin
        nxt = cur_q;
        if (step) begin
            unique case (cur_q)
                SEL_AE_LO: nxt = SEL_AE_HI;
                SEL_AE_HI: nxt = SEL_AF_LO;
                SEL_AF_LO: nxt = SEL_AF_HI;
                SEL_AF_HI: nxt = SEL_AE_LO;
            endcase
        end
    end

    // outputs
    always_comb begin
        sel_oh = '0;
        unique case (cur_q)
            SEL_AE_LO: sel_oh[0] = 1'b1;
            SEL_AE_HI: sel_oh[1] = 1'b1;
            SEL_AF_LO: sel_oh[2] = 1'b1;
            SEL_AF_HI: sel_oh[3] = 1'b1;
        endcase
    end

    // R1: after the last slot the sequencer returns to the first
    a_r1_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (step && cur_q == SEL_AF_HI) |=> (cur_q == SEL_AE_LO));

    // R3: position is kept across idle cycles
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(cur_q));

    // R1: exactly one slot selected at any time
    a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(sel_oh) == 1);

endmodule

// File: rtl/ofs_wr_bank.sv
module ofs_wr_bank
    import ofs_pkg::*;
#(
    parameter int DW   = 9,
    parameter int HI_W = 2
) (
    input  logic                         wr_clk,
    input  logic                         rst_n,
    input  logic                         ld_n,
    input  logic                         wen1_n,
    input  logic [DW-1:0]                din,
    output logic [2*(LO_W+HI_W)-1:0]     ofs_bus,
    output logic [LO_W+HI_W-1:0]         af_ofs,
    output logic                         upd_tog
);

    localparam int OFS_W = LO_W + HI_W;
    localparam logic [LO_W-1:0] DEF_LO = LO_W'(OFS_DEF);
    localparam logic [2*OFS_W-1:0] DEF_BUS =
        {{HI_W{1'b0}}, DEF_LO, {HI_W{1'b0}}, DEF_LO};

    logic                    two_wen_q;
    logic                    wr_go;
    logic                    wr_go_q;
    logic [3:0]              sel_oh;
    logic [1:0][LO_W-1:0]    lo_q;
    logic [1:0][HI_W-1:0]    hi_q;
    logic                    unused_din;

    assign unused_din = ^din;

    // mode is captured while reset is held
    always_ff @(posedge wr_clk) begin
        if (!rst_n) two_wen_q <= ld_n;
    end

    assign wr_go = !two_wen_q && !ld_n && !wen1_n;

    ofs_seq u_wseq (
        .clk    (wr_clk),
        .rst_n  (rst_n),
        .step   (wr_go),
        .sel_oh (sel_oh)
    );

    always_ff @(posedge wr_clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 2; i++) begin
                lo_q[i] <= DEF_LO;
                hi_q[i] <= '0;
            end
        end else if (wr_go) begin
            for (int i = 0; i < 2; i++) begin
                if (sel_oh[2*i])   lo_q[i] <= din[LO_W-1:0];
                if (sel_oh[2*i+1]) hi_q[i] <= din[HI_W-1:0];
            end
        end
    end

    // one toggle per finished burst, sent once the slots are stable
    always_ff @(posedge wr_clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_go_q <= 1'b0;
            upd_tog <= 1'b0;
        end else begin
            wr_go_q <= wr_go;
            if (wr_go_q && !wr_go) upd_tog <= ~upd_tog;
        end
    end

    assign ofs_bus = {hi_q[1], lo_q[1], hi_q[0], lo_q[0]};
    assign af_ofs  = {hi_q[1], lo_q[1]};

    // R2: slots change only on a qualifying write
    a_r2_no_stray_write: assert property (@(posedge wr_clk) disable iff (!rst_n)
        !wr_go |=> $stable(ofs_bus));

    // R8: second-enable mode keeps defaults
    a_r8_mode_default: assert property (@(posedge wr_clk) disable iff (!rst_n)
        two_wen_q |-> (ofs_bus == DEF_BUS));

endmodule

// File: rtl/ofs_cdc.sv
module ofs_cdc
    import ofs_pkg::*;
#(
    parameter int HI_W = 2
) (
    input  logic                         rd_clk,
    input  logic                         rst_n,
    input  logic                         upd_tog,
    input  logic [2*(LO_W+HI_W)-1:0]     src_bus,
    output logic                         busy,
    output logic [2*(LO_W+HI_W)-1:0]     shadow
);

    localparam int OFS_W = LO_W + HI_W;
    localparam logic [LO_W-1:0] DEF_LO = LO_W'(OFS_DEF);
    localparam logic [2*OFS_W-1:0] DEF_BUS =
        {{HI_W{1'b0}}, DEF_LO, {HI_W{1'b0}}, DEF_LO};

    logic s1_q, s2_q, s3_q;
    logic take;

    always_ff @(posedge rd_clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
            s3_q <= 1'b0;
        end else begin
            s1_q <= upd_tog;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    assign take = s2_q ^ s3_q;
    assign busy = (s1_q ^ s3_q) | (s2_q ^ s3_q);

    always_ff @(posedge rd_clk or negedge rst_n) begin
        if (!rst_n)    shadow <= DEF_BUS;
        else if (take) shadow <= src_bus;
    end

    // R9: read-side copy moves only while an update is in flight
    a_r9_shadow_quiet: assert property (@(posedge rd_clk) disable iff (!rst_n)
        !busy |=> $stable(shadow));

endmodule

// File: rtl/ofs_rd_port.sv
module ofs_rd_port
    import ofs_pkg::*;
#(
    parameter int DW   = 9,
    parameter int HI_W = 2
) (
    input  logic                         rd_clk,
    input  logic                         rst_n,
    input  logic                         ld_n,
    input  logic                         ren1_n,
    input  logic                         ren2_n,
    input  logic                         busy,
    input  logic [2*(LO_W+HI_W)-1:0]     shadow,
    output logic [DW-1:0]                rd_data,
    output logic                         clash_err
);

    localparam int OFS_W = LO_W + HI_W;

    logic            two_wen_q;
    logic            rd_req;
    logic            rd_go;
    logic [3:0]      sel_oh;
    logic [DW-1:0]   rd_val;

    always_ff @(posedge rd_clk) begin
        if (!rst_n) two_wen_q <= ld_n;
    end

    assign rd_req = !two_wen_q && !ld_n && !ren1_n && !ren2_n;
    assign rd_go  = rd_req && !busy;

    ofs_seq u_rseq (
        .clk    (rd_clk),
        .rst_n  (rst_n),
        .step   (rd_go),
        .sel_oh (sel_oh)
    );

    always_comb begin
        rd_val = '0;
        unique case (1'b1)
            sel_oh[0]: rd_val[LO_W-1:0] = shadow[LO_W-1:0];
            sel_oh[1]: rd_val[HI_W-1:0] = shadow[OFS_W-1:LO_W];
            sel_oh[2]: rd_val[LO_W-1:0] = shadow[OFS_W+LO_W-1:OFS_W];
            sel_oh[3]: rd_val[HI_W-1:0] = shadow[2*OFS_W-1:OFS_W+LO_W];
            default:   rd_val = '0;
        endcase
    end

    always_ff @(posedge rd_clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data   <= '0;
            clash_err <= 1'b0;
        end else begin
            if (rd_go)           rd_data   <= rd_val;
            if (rd_req && busy)  clash_err <= 1'b1;
        end
    end

    // R4: output register holds without a qualifying read
    a_r4_data_hold: assert property (@(posedge rd_clk) disable iff (!rst_n)
        !rd_go |=> $stable(rd_data));

    // R7: a colliding read leaves the output untouched
    a_r7_clash_no_data: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (rd_req && busy) |=> ($stable(rd_data) && clash_err));

    // R7: the collision flag is sticky
    a_r7_clash_sticky: assert property (@(posedge rd_clk) disable iff (!rst_n)
        clash_err |=> clash_err);

endmodule

// File: rtl/ofs_regfile.sv
module ofs_regfile
    import ofs_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int DW    = 9
) (
    input  logic                  wr_clk,
    input  logic                  rd_clk,
    input  logic                  rst_n,
    input  logic                  ld_n,
    input  logic                  wen1_n,
    input  logic [DW-1:0]         din,
    input  logic                  ren1_n,
    input  logic                  ren2_n,
    output logic [DW-1:0]         rd_data,
    output logic                  clash_err,
    output logic [LO_W+((($clog2(DEPTH))>LO_W)?($clog2(DEPTH)-LO_W):1)-1:0] ae_ofs,
    output logic [LO_W+((($clog2(DEPTH))>LO_W)?($clog2(DEPTH)-LO_W):1)-1:0] af_ofs
);

    localparam int AW    = $clog2(DEPTH);
    localparam int HI_W  = (AW > LO_W) ? (AW - LO_W) : 1;
    localparam int OFS_W = LO_W + HI_W;

    logic [2*OFS_W-1:0] wr_bus;
    logic [2*OFS_W-1:0] rd_shadow;
    logic               upd_tog;
    logic               xfer_busy;

    ofs_wr_bank #(.DW(DW), .HI_W(HI_W)) u_bank (
        .wr_clk  (wr_clk),
        .rst_n   (rst_n),
        .ld_n    (ld_n),
        .wen1_n  (wen1_n),
        .din     (din),
        .ofs_bus (wr_bus),
        .af_ofs  (af_ofs),
        .upd_tog (upd_tog)
    );

    ofs_cdc #(.HI_W(HI_W)) u_cdc (
        .rd_clk  (rd_clk),
        .rst_n   (rst_n),
        .upd_tog (upd_tog),
        .src_bus (wr_bus),
        .busy    (xfer_busy),
        .shadow  (rd_shadow)
    );

    ofs_rd_port #(.DW(DW), .HI_W(HI_W)) u_rport (
        .rd_clk    (rd_clk),
        .rst_n     (rst_n),
        .ld_n      (ld_n),
        .ren1_n    (ren1_n),
        .ren2_n    (ren2_n),
        .busy      (xfer_busy),
        .shadow    (rd_shadow),
        .rd_data   (rd_data),
        .clash_err (clash_err)
    );

    assign ae_ofs = rd_shadow[OFS_W-1:0];

endmodule

// File: tb/ofs_regfile_tb_top.sv
module ofs_regfile_tb_top;

    localparam int DEPTH = 1024;
    localparam int DW    = 9;
    localparam int AW    = $clog2(DEPTH);
    localparam int HI_W  = (AW > 8) ? (AW - 8) : 1;
    localparam int OFS_W = 8 + HI_W;
    localparam int HMASK = (1 << HI_W) - 1;

    logic wr_clk = 1'b0;
    logic rd_clk = 1'b0;
    logic rst_n  = 1'b0;
    logic ld_n   = 1'b1;
    logic wen1_n = 1'b1;
    logic ren1_n = 1'b1;
    logic ren2_n = 1'b1;
    logic [DW-1:0]    din = '0;
    logic [DW-1:0]    rd_data;
    logic             clash_err;
    logic [OFS_W-1:0] ae_ofs;
    logic [OFS_W-1:0] af_ofs;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;
    bit  prog   = 1'b1;
    int  m_lo [2];
    int  m_hi [2];
    int  wp, rp, last_rd;

    ofs_regfile #(.DEPTH(DEPTH), .DW(DW)) dut_i (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .ld_n(ld_n),
        .wen1_n(wen1_n), .din(din), .ren1_n(ren1_n), .ren2_n(ren2_n),
        .rd_data(rd_data), .clash_err(clash_err),
        .ae_ofs(ae_ofs), .af_ofs(af_ofs)
    );

    always #4 wr_clk = ~wr_clk;
    initial begin
        #3;
        forever #4 rd_clk = ~rd_clk;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int m_ofs(input int i);
        return (m_hi[i] << 8) | m_lo[i];
    endfunction

    function automatic int m_slot(input int p);
        case (p)
            0: return m_lo[0];
            1: return m_hi[0];
            2: return m_lo[1];
            default: return m_hi[1];
        endcase
    endfunction

    function automatic void m_write(input int v);
        case (wp)
            0: m_lo[0] = v & 255;
            1: m_hi[0] = v & HMASK;
            2: m_lo[1] = v & 255;
            default: m_hi[1] = v & HMASK;
        endcase
        wp = (wp + 1) % 4;
    endfunction

    task automatic do_reset(input logic mode_ld);
        @(negedge wr_clk);
        rst_n = 1'b0; ld_n = mode_ld; wen1_n = 1'b1; ren1_n = 1'b1; ren2_n = 1'b1;
        repeat (4) @(posedge wr_clk);
        @(negedge wr_clk);
        rst_n = 1'b1;
        prog = !mode_ld;
        m_lo[0] = 7; m_lo[1] = 7; m_hi[0] = 0; m_hi[1] = 0;
        wp = 0; rp = 0; last_rd = 0;
        @(negedge wr_clk);
    endtask

    task automatic wr_one(input int v);
        @(negedge wr_clk);
        ld_n = 1'b0; wen1_n = 1'b0; din = DW'(v);
        @(posedge wr_clk);
        if (prog) m_write(v);
        @(negedge wr_clk);
        wen1_n = 1'b1;
        chk("R1/R5/R9 af_ofs after slot write", int'(af_ofs), m_ofs(1));
    endtask

    task automatic settle();
        repeat (6) @(posedge rd_clk);
        @(negedge rd_clk);
    endtask

    task automatic rd_one(input string tag);
        int exp;
        @(negedge rd_clk);
        ld_n = 1'b0; ren1_n = 1'b0; ren2_n = 1'b0;
        @(posedge rd_clk);
        @(negedge rd_clk);
        ren1_n = 1'b1; ren2_n = 1'b1;
        if (prog) begin
            exp = m_slot(rp);
            rp = (rp + 1) % 4;
        end else begin
            exp = 0;
        end
        last_rd = exp;
        chk(tag, int'(rd_data), exp);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual %0d expected %0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R6 reset state
        do_reset(1'b0);
        chk("R6 af_ofs default", int'(af_ofs), 7);
        chk("R6 ae_ofs default", int'(ae_ofs), 7);
        chk("R6 rd_data cleared", int'(rd_data), 0);
        chk("R6 clash_err cleared", int'(clash_err), 0);
        rd_one("R6 first readback is n-low default");

        // R1/R5/R9 sweep over three wraps
        for (int k = 0; k < 12; k++) begin
            wr_one((k * 73 + 11) % 512);
            settle();
            chk("R9 ae_ofs follows write", int'(ae_ofs), m_ofs(0));
        end

        // R4 readback order with wrap
        for (int k = 0; k < 9; k++) rd_one("R4 readback order");

        // R4 one enable high: no read
        @(negedge rd_clk); ren1_n = 1'b0; ren2_n = 1'b1;
        @(posedge rd_clk); @(negedge rd_clk);
        ren1_n = 1'b1;
        chk("R4 ren2 high holds data", int'(rd_data), last_rd);
        @(negedge rd_clk); ren1_n = 1'b1; ren2_n = 1'b0;
        @(posedge rd_clk); @(negedge rd_clk);
        ren2_n = 1'b1;
        chk("R4 ren1 high holds data", int'(rd_data), last_rd);
        rd_one("R4 read pointer held by partial enable");

        // R2 no write without both controls low
        @(negedge wr_clk); ld_n = 1'b1; wen1_n = 1'b0; din = 9'h1AA;
        repeat (3) @(negedge wr_clk);
        ld_n = 1'b0; wen1_n = 1'b1;
        repeat (3) @(negedge wr_clk);
        settle();
        chk("R2 af_ofs unchanged", int'(af_ofs), m_ofs(1));
        chk("R2 ae_ofs unchanged", int'(ae_ofs), m_ofs(0));
        wr_one(9'h0C3);
        settle();
        chk("R2 write pointer unmoved", int'(ae_ofs), m_ofs(0));

        // R3 partial burst, resumed (R6: reset restarts the pointer)
        do_reset(1'b0);
        wr_one(9'h015);
        wr_one(9'h1FF);
        @(negedge wr_clk); ld_n = 1'b1;
        repeat (5) @(negedge wr_clk);
        wr_one(9'h0A5);
        chk("R3 resume lands on m-low", int'(af_ofs), 'h0A5);
        settle();
        chk("R3/R5 n from paused burst", int'(ae_ofs), (3 << 8) | 'h15);
        wr_one(9'h002);
        chk("R5 m high slot masked", int'(af_ofs), (2 << 8) | 'hA5);

        // R9 latency bound
        wr_one(9'h03C);
        chk("R9 ae_ofs old right after write", int'(ae_ofs), (3 << 8) | 'h15);
        settle();
        chk("R9 ae_ofs new after sync", int'(ae_ofs), (3 << 8) | 'h3C);

        // R7 read colliding with a crossing update
        rd_one("R7 pre-clash readback");
        chk("R7 no clash yet", int'(clash_err), 0);
        @(negedge wr_clk); ld_n = 1'b0; wen1_n = 1'b0; din = 9'h001;
        @(posedge wr_clk);
        m_write(1);
        @(negedge wr_clk); wen1_n = 1'b1;
        @(posedge rd_clk);
        @(negedge rd_clk); ren1_n = 1'b0; ren2_n = 1'b0;
        @(posedge rd_clk);
        @(negedge rd_clk); ren1_n = 1'b1; ren2_n = 1'b1;
        chk("R7 clash flagged", int'(clash_err), 1);
        chk("R7 colliding read returns nothing new", int'(rd_data), last_rd);
        settle();
        chk("R7 write took effect", int'(ae_ofs), (1 << 8) | 'h3C);
        rd_one("R7 read pointer held after clash");
        chk("R7 clash sticky", int'(clash_err), 1);

        // R8 second-enable mode
        do_reset(1'b1);
        wr_one(9'h055);
        wr_one(9'h066);
        wr_one(9'h077);
        settle();
        chk("R8 m stays default", int'(af_ofs), 7);
        chk("R8 n stays default", int'(ae_ofs), 7);
        rd_one("R8 readback ignored");
        chk("R8 no clash", int'(clash_err), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule